// File: doc/BRIEF.md
# Two-Wire Register-File Slave

This block is a slave on a two-wire serial bus. It lets a bus master read and write a 256-byte register array held inside the block. A fast system clock samples the bus lines. Each line passes through a synchroniser, and the block then looks for clock edges and for the START and STOP conditions. The block answers to one 7-bit device address, and the low bit of that address comes from a select pin. The data line is never driven high. The block only pulls it low, through an output-enable signal.

An 8-bit pointer selects the array location. The pointer persists between transfers and wraps from FFh to 00h. In a write transfer, the first data byte loads the pointer and each later byte is stored at the pointer before the pointer advances. A read transfer starts at the pointer's current location, and each byte the master acknowledges is followed by the next location. To read from a chosen location, the master writes a one-byte pointer, issues a repeated START and then reads.

Top module: `tw_reg_slave`

## Requirements
- R1: A START (data falling while the clock is high) begins a new address phase from any state, including the middle of a byte. The bits already shifted in are discarded and nothing is written.
- R2: A STOP (data rising while the clock is high) returns the block to idle with the data line released. Bytes clocked afterwards without a START get no acknowledge.
- R3: The first byte after a START is compared MSB first against the device address 1010000 when the select pin is 0, or 1010001 when it is 1, followed by a direction bit (1 = read, 0 = write). On a match the block pulls the data line low for the whole ninth clock.
- R4: If the address does not match, the block gives no acknowledge and ignores all clocks until the next START. The array and the pointer stay unchanged.
- R5: In a write, the first data byte loads the pointer. Each later byte is stored at the pointer, and the pointer then advances by one. Every byte is acknowledged.
- R6: A read transfer sends, MSB first, the byte at the current pointer right after the address acknowledge. The pointer then advances by one, so a second read transfer returns the next location.
- R7: A write of a pointer byte followed by a repeated START and a read returns the byte stored at that pointer.
- R8: During a read, each master acknowledge (data low on the ninth clock) causes the next location to be sent. The pointer wraps from FFh to 00h in both reads and writes.
- R9: A master not-acknowledge (data high on the ninth clock) ends the read. The block leaves the data line released until the next START.
- R10: After reset, every array byte is 00h, the pointer is 00h and the data line is released.
- R11: The output enable changes only while the synchronised clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| addr_sel_i | input | 1 | Selects the low bit of the device address |
| sda_oe_o | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The bench models the bus as a wired-AND of master and slave and aims at the points where a slave commonly goes wrong. It writes across FFh: a pointer that did not wrap would send the third byte to 100h truncated wrongly or never reach location 00h, so the readback would differ. It issues a repeated START three bits into a data byte, which catches a block that ends the partial byte as a write or loses the pointer. It also sends a wrong address, a STOP followed by stray clocks, and a not-acknowledge. In each of these cases a faulty block would acknowledge, store data or keep pulling the line low. A line monitor also flags any change of the output enable while the clock line is high, because such a change would be seen on the bus as a false START or STOP.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK
  } tw_state_e;

  // Device address: upper six bits fixed, lowest bit from the select pin.
  function automatic logic [6:0] dev_addr(input logic [6:0] base, input logic sel);
    return {base[6:1], sel};
  endfunction

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES:0] chain;
  assign chain[0] = d_i;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g+1] <= 1'b1;
      else        chain[g+1] <= chain[g];
    end
  end

  assign q_o = chain[STAGES];

endmodule

// File: rtl/tw_bus_events.sv
module tw_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise,
  output logic scl_fall
);

  logic scl_q, sda_q;
  logic scl_high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_high = scl_q & scl_s;
  assign start_ev = scl_high & sda_q & ~sda_s;
  assign stop_ev  = scl_high & ~sda_q & sda_s;
  assign scl_rise = ~scl_q & scl_s;
  assign scl_fall = scl_q & ~scl_s;

endmodule

// File: rtl/tw_regfile.sv
module tw_regfile #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  // R5
  wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/tw_engine.sv
module tw_engine #(
  parameter int         AW        = 8,
  parameter int         DW        = 8,
  parameter logic [6:0] BASE_ADDR = 7'b1010000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_i,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sel_i,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_raddr,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata,
  output logic          sda_oe_o
);
  import tw_pkg::*;

  localparam int CW = $clog2(DW + 1);

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return p + AW'(1);
  endfunction

  tw_state_e     state;
  logic [DW-1:0] rx_sr, tx_sr;
  logic [CW-1:0] bit_cnt;
  logic [AW-1:0] ptr;
  logic          rd_mode, first_byte, m_ack, oe_q;

  // Named internal events
  logic byte_done, addr_hit, ptr_load, wr_fire, rd_fetch, ptr_inc, tx_last;

  assign byte_done = scl_fall && (bit_cnt == CW'(DW));
  assign addr_hit  = (rx_sr[DW-1 -: 7] == dev_addr(BASE_ADDR, sel_i));
  assign ptr_load  = byte_done && (state == ST_WR_BYTE) && first_byte;
  assign wr_fire   = byte_done && (state == ST_WR_BYTE) && !first_byte;
  assign rd_fetch  = scl_fall && (((state == ST_ADDR_ACK) && rd_mode) ||
                                  ((state == ST_RD_ACK) && m_ack));
  assign ptr_inc   = wr_fire || rd_fetch;
  assign tx_last   = scl_fall && (state == ST_RD_BYTE) && (bit_cnt == CW'(DW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      rx_sr      <= '0;
      tx_sr      <= '0;
      bit_cnt    <= '0;
      rd_mode    <= 1'b0;
      first_byte <= 1'b0;
      m_ack      <= 1'b0;
      oe_q       <= 1'b0;
    end else if (start_ev) begin
      state   <= ST_ADDR;
      bit_cnt <= '0;
      oe_q    <= 1'b0;
    end else if (stop_ev) begin
      state <= ST_IDLE;
      oe_q  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: ;
        ST_ADDR: begin
          if (scl_rise) begin
            rx_sr   <= {rx_sr[DW-2:0], sda_i};
            bit_cnt <= bit_cnt + CW'(1);
          end else if (byte_done) begin
            bit_cnt <= '0;
            if (addr_hit) begin
              state   <= ST_ADDR_ACK;
              oe_q    <= 1'b1;
              rd_mode <= rx_sr[0];
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            if (rd_mode) begin
              tx_sr <= mem_rdata;
              oe_q  <= ~mem_rdata[DW-1];
              state <= ST_RD_BYTE;
            end else begin
              oe_q       <= 1'b0;
              first_byte <= 1'b1;
              state      <= ST_WR_BYTE;
            end
          end
        end
        ST_WR_BYTE: begin
          if (scl_rise) begin
            rx_sr   <= {rx_sr[DW-2:0], sda_i};
            bit_cnt <= bit_cnt + CW'(1);
          end else if (byte_done) begin
            bit_cnt    <= '0;
            oe_q       <= 1'b1;
            first_byte <= 1'b0;
            state      <= ST_WR_ACK;
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            oe_q  <= 1'b0;
            state <= ST_WR_BYTE;
          end
        end
        ST_RD_BYTE: begin
          if (tx_last) begin
            bit_cnt <= '0;
            oe_q    <= 1'b0;
            state   <= ST_RD_ACK;
          end else if (scl_fall) begin
            tx_sr   <= {tx_sr[DW-2:0], 1'b0};
            oe_q    <= ~tx_sr[DW-2];
            bit_cnt <= bit_cnt + CW'(1);
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            m_ack <= ~sda_i;
          end else if (scl_fall) begin
            if (m_ack) begin
              tx_sr <= mem_rdata;
              oe_q  <= ~mem_rdata[DW-1];
              state <= ST_RD_BYTE;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Persistent pointer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr <= '0;
    else if (ptr_load) ptr <= rx_sr[AW-1:0];
    else if (ptr_inc)  ptr <= ptr_next(ptr);
  end

  assign mem_raddr = ptr;
  assign mem_we    = wr_fire;
  assign mem_waddr = ptr;
  assign mem_wdata = rx_sr;
  assign sda_oe_o  = oe_q;

  // R1
  start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (state == ST_ADDR && bit_cnt == '0 && !oe_q));

  // R2
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ev && !start_ev) |=> (state == ST_IDLE && !oe_q));

  // R3
  ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR_ACK || state == ST_WR_ACK) |-> oe_q);

  // R4
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR && byte_done && !addr_hit && !start_ev && !stop_ev)
      |=> (state == ST_IDLE && !oe_q));

  // R8
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_inc && !ptr_load && ptr == '1) |=> (ptr == '0));

  // R9
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD_ACK && scl_fall && !m_ack && !start_ev && !stop_ev)
      |=> (state == ST_IDLE && !oe_q));

  // R9
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !oe_q);

endmodule

// File: rtl/tw_reg_slave.sv
module tw_reg_slave #(
  parameter int         SYNC_STAGES = 2,
  parameter int         AW          = 8,
  parameter int         DW          = 8,
  parameter logic [6:0] BASE_ADDR   = 7'b1010000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic addr_sel_i,
  output logic sda_oe_o
);

  logic          scl_s, sda_s;
  logic          start_ev, stop_ev, scl_rise, scl_fall;
  logic          mem_we;
  logic [AW-1:0] mem_raddr, mem_waddr;
  logic [DW-1:0] mem_rdata, mem_wdata;

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s));

  tw_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s));

  tw_bus_events u_events (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .scl_rise(scl_rise), .scl_fall(scl_fall));

  tw_regfile #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr),
    .wdata(mem_wdata), .raddr(mem_raddr), .rdata(mem_rdata));

  tw_engine #(.AW(AW), .DW(DW), .BASE_ADDR(BASE_ADDR)) u_engine (
    .clk(clk), .rst_n(rst_n), .sda_i(sda_s),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sel_i(addr_sel_i), .mem_rdata(mem_rdata), .mem_raddr(mem_raddr),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .sda_oe_o(sda_oe_o));

  // R11
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_s);

endmodule

// File: tb/tw_reg_slave_bench.sv
module tw_reg_slave_bench;

  localparam int H = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sel = 1'b0;
  logic sda_oe;
  logic sda_bus;

  int checks = 0;
  int errors = 0;
  int oe_viol = 0;
  int cyc = 0;
  logic [7:0] exp_mem [256];
  logic [7:0] ptr_m = 8'h00;

  always #2.5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  tw_reg_slave u_tw_reg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_sel_i(sel), .sda_oe_o(sda_oe));

  // Table: {pointer, data} for single-byte write and random-read pairs
  localparam logic [15:0] VEC [6] = '{16'h105A, 16'h33C9, 16'h7F81,
                                      16'h8018, 16'hC4E7, 16'hE93C};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_h();
    repeat (H) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wait_h();
    sda_m = 1'b0; wait_h();
    scl_m = 1'b0; wait_h();
  endtask

  task automatic rep_start();
    sda_m = 1'b1; wait_h();
    scl_m = 1'b1; wait_h();
    sda_m = 1'b0; wait_h();
    scl_m = 1'b0; wait_h();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_h();
    scl_m = 1'b1; wait_h();
    sda_m = 1'b1; wait_h();
  endtask

  task automatic clock_bit(input logic b);
    sda_m = b; wait_h();
    scl_m = 1'b1; wait_h();
    scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) clock_bit(b[i]);
    sda_m = 1'b1; wait_h();
    scl_m = 1'b1;
    repeat (H/2) @(negedge clk);
    ack = ~sda_bus;
    repeat (H/2) @(negedge clk);
    scl_m = 1'b0;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_h();
      scl_m = 1'b1;
      repeat (H/2) @(negedge clk);
      b[i] = sda_bus;
      repeat (H/2) @(negedge clk);
      scl_m = 1'b0;
    end
    sda_m = give_ack ? 1'b0 : 1'b1;
    wait_h();
    scl_m = 1'b1; wait_h();
    scl_m = 1'b0;
    sda_m = 1'b1;
  endtask

  task automatic wr_bytes(input logic [7:0] p, input logic [7:0] d [], input string req);
    logic a;
    bus_start();
    send_byte({7'h50, 1'b0}, a); chk({req, " addr ack"}, {7'd0, a}, 8'h01);
    send_byte(p, a);             chk({req, " ptr ack"}, {7'd0, a}, 8'h01);
    ptr_m = p;
    foreach (d[k]) begin
      send_byte(d[k], a);        chk({req, " data ack"}, {7'd0, a}, 8'h01);
      exp_mem[ptr_m] = d[k];
      ptr_m = ptr_m + 8'd1;
    end
    bus_stop();
  endtask

  task automatic rand_read(input logic [7:0] p, input int n, input string req);
    logic a;
    logic [7:0] v;
    bus_start();
    send_byte({7'h50, 1'b0}, a);
    send_byte(p, a);
    rep_start();
    send_byte({7'h50, 1'b1}, a); chk({req, " read addr ack"}, {7'd0, a}, 8'h01);
    ptr_m = p;
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, v);
      chk(req, v, exp_mem[ptr_m]);
      ptr_m = ptr_m + 8'd1;
    end
    bus_stop();
  endtask

  task automatic cur_read(input string req);
    logic a;
    logic [7:0] v;
    bus_start();
    send_byte({7'h50, 1'b1}, a); chk({req, " addr ack"}, {7'd0, a}, 8'h01);
    recv_byte(1'b0, v);
    chk(req, v, exp_mem[ptr_m]);
    ptr_m = ptr_m + 8'd1;
    bus_stop();
  endtask

  // R11 line monitor: enable must not move while the clock line is high
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_prev && scl_m) oe_viol++;
    oe_prev <= sda_oe;
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, 190000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] v;
    logic [7:0] d1 [];
    logic [7:0] d3 [];
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
    repeat (5) @(negedge clk);
    chk("R10 oe in reset", {7'd0, sda_oe}, 8'h00);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10 oe after reset", {7'd0, sda_oe}, 8'h00);

    // R10 / R6: first read at pointer 00h returns reset value 00h
    cur_read("R10 R6 first current read");

    // Table walk: R5 single writes, R7 random reads
    for (int t = 0; t < 6; t++) begin
      d1 = new[1];
      d1[0] = VEC[t][7:0];
      wr_bytes(VEC[t][15:8], d1, "R5 table write");
      rand_read(VEC[t][15:8], 1, "R7 table random read");
    end

    // R5 / R8: three bytes across FFh, then sequential read across the wrap
    d3 = new[3];
    d3[0] = 8'hA1; d3[1] = 8'hB2; d3[2] = 8'hC3;
    wr_bytes(8'hFE, d3, "R8 wrap write");
    rand_read(8'hFE, 3, "R8 sequential wrap read");

    // R6: pointer-only write, then two current reads step through locations
    d1 = new[0];
    wr_bytes(8'h7F, d1, "R6 pointer set");
    cur_read("R6 current read 7F");
    cur_read("R6 current read 80");

    // R4: wrong address gets no ack, following byte is ignored
    bus_start();
    send_byte({7'h51, 1'b0}, a); chk("R4 wrong addr nack", {7'd0, a}, 8'h00);
    send_byte(8'h10, a);         chk("R4 byte ignored", {7'd0, a}, 8'h00);
    send_byte(8'hEE, a);
    bus_stop();
    cur_read("R4 state unchanged");
    rand_read(8'h10, 1, "R4 array unchanged");

    // R3: select pin moves the address low bit
    sel = 1'b1;
    bus_start();
    send_byte({7'h50, 1'b1}, a); chk("R3 sel=1 old addr nack", {7'd0, a}, 8'h00);
    bus_stop();
    bus_start();
    send_byte({7'h51, 1'b1}, a); chk("R3 sel=1 new addr ack", {7'd0, a}, 8'h01);
    recv_byte(1'b0, v);          chk("R3 sel=1 read data", v, exp_mem[ptr_m]);
    ptr_m = ptr_m + 8'd1;
    // R9: after the not-acknowledge the line stays released
    wait_h();
    chk("R9 released after nack", {7'd0, sda_oe}, 8'h00);
    clock_bit(1'b1);
    chk("R9 still released", {7'd0, sda_oe}, 8'h00);
    bus_stop();
    sel = 1'b0;

    // R1: repeated START three bits into a data byte
    bus_start();
    send_byte({7'h50, 1'b0}, a);
    send_byte(8'h33, a);
    clock_bit(1'b1); clock_bit(1'b0); clock_bit(1'b1);
    rep_start();
    send_byte({7'h50, 1'b1}, a); chk("R1 restart addr ack", {7'd0, a}, 8'h01);
    recv_byte(1'b0, v);          chk("R1 partial byte discarded", v, exp_mem[8'h33]);
    bus_stop();
    ptr_m = 8'h34;

    // R2: after STOP stray clocks get no acknowledge
    bus_start();
    send_byte({7'h50, 1'b0}, a);
    bus_stop();
    scl_m = 1'b0; wait_h();
    send_byte(8'hA0, a);         chk("R2 no ack after stop", {7'd0, a}, 8'h00);
    send_byte(8'h55, a);
    scl_m = 1'b1; wait_h();
    cur_read("R2 pointer unchanged");

    chk("R11 enable moved while clock high", oe_viol[7:0], 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule